// File: doc/BRIEF.md
# Oscillator Startup Timer Controller

This block gates the main crystal oscillator on and off and decides when its output can be trusted. Everything runs from the always-present slow clock. Software writes an enable bit together with a startup count. The block then waits a number of slow-clock cycles derived from that count before it raises a "main clock stable" flag. A prescaler divides the slow clock by a power of two (eight by default), and the countdown advances only on those divided ticks. This keeps the delay long enough for a crystal without needing a wide counter.

Three small registers sit behind a single write strobe with a two-bit register select:
- an oscillator control register holding the enable bit and the startup count;
- an interrupt mask bit;
- a system clock source flag that chooses between the slow clock and the main clock.

After reset the oscillator is off and the slow clock is selected. A request to switch to the main clock is refused until the stable flag is high. When the flag drops, the selection falls back to the slow clock.

Top module: `osc_startup_ctrl`

## Requirements
- R1: After reset, osc_on_o, osc_stable_o, main_sel_o and irq_o are all 0, and the interrupt mask is 0.
- R2: A write with wr_addr = 0 is a control write: wr_data[0] is the enable bit and wr_data[8:1] is the startup count N. With wr_data[0] = 1, osc_on_o is 1 and osc_stable_o is 0 from the cycle after the write edge.
- R3: A control write with wr_data[0] = 0 makes osc_on_o and osc_stable_o 0 from the cycle after the write edge.
- R4: After an enabling control write, osc_stable_o rises exactly 8 × max(N,1) clock cycles after the write edge. The prescaler restarts on every such write, so the delay is never shortened by a partial divided period. A count of 0 behaves like a count of 1.
- R5: Once high, osc_stable_o stays high until the next control write.
- R6: An enabling control write during a countdown, or while stable, clears osc_stable_o and restarts the full delay from that write.
- R7: A write with wr_addr = 1 sets the interrupt mask to wr_data[0]. When the mask is 1, irq_o is high for exactly one cycle, the cycle in which osc_stable_o first reads 1. When the mask is 0, irq_o stays 0.
- R8: A write with wr_addr = 2 sets the clock source: wr_data[0] = 1 requests the main clock and is honoured only if osc_stable_o is 1 at that edge; otherwise main_sel_o stays 0. wr_data[0] = 0 selects the slow clock.
- R9: Whenever osc_stable_o falls, main_sel_o is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 interrupt mask, 2 clock source |
| wr_data | input | CNT_W+1 | Write data; bit 0 is the flag, bits CNT_W:1 the startup count |
| osc_on_o | output | 1 | Oscillator enable |
| osc_stable_o | output | 1 | Main clock stable status |
| main_sel_o | output | 1 | 1 when the main clock is the selected source |
| irq_o | output | 1 | One-cycle pulse on the rise of the stable flag when unmasked |

## Verification
The bench builds the block with its defaults: an 8-bit startup count and a divide-by-8 prescaler. With these values the largest count of 255 finishes in 2040 cycles, so the full-scale delay is measured alongside the zero and one corner cases. A restart in the middle of a countdown shows that the prescaler phase does not carry over. Mask on/off passes and clock-select attempts both before and after stability cover the refusal and fall-back paths.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

    localparam int CNT_W_DEF    = 8;
    localparam int DIV_LOG2_DEF = 3;

    typedef enum logic [1:0] {
        REG_OSC_CTRL = 2'd0,
        REG_IRQ_MASK = 2'd1,
        REG_CLK_SRC  = 2'd2,
        REG_UNUSED   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic osc_wr;
        logic mask_wr;
        logic src_wr;
    } wr_decode_t;

    function automatic wr_decode_t decode_write(input logic en, input reg_sel_e sel);
        wr_decode_t d;
        d.osc_wr  = en && (sel == REG_OSC_CTRL);
        d.mask_wr = en && (sel == REG_IRQ_MASK);
        d.src_wr  = en && (sel == REG_CLK_SRC);
        return d;
    endfunction

endpackage

// File: rtl/osc_prescaler.sv
module osc_prescaler
    import osc_startup_pkg::*;
#(
    parameter int DIV_LOG2 = DIV_LOG2_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam logic [DIV_LOG2-1:0] PH_LAST = '1;

    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && !restart && (phase_q == PH_LAST);

    // divided ticks are never back to back
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/osc_countdown.sv
module osc_countdown
    import osc_startup_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    input  logic             tick,
    output logic             active,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             last_tick;

    assign last_tick = active_q && tick && !load && !stop && (cnt_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            cnt_q    <= load_val;
            active_q <= 1'b1;
        end else if (stop) begin
            active_q <= 1'b0;
        end else if (active_q && tick) begin
            if (cnt_q <= ONE) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign active = active_q;
    assign done   = last_tick;

    assert_load_takes_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (active_q && cnt_q == $past(load_val)));

    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> !active_q);

endmodule

// File: rtl/osc_status.sv
module osc_status
    import osc_startup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic osc_wr,
    input  logic osc_bit,
    input  logic done,
    input  logic mask_wr,
    input  logic mask_bit,
    input  logic src_wr,
    input  logic src_bit,
    output logic osc_on,
    output logic stable,
    output logic main_sel,
    output logic irq
);
    logic osc_on_q, stable_q, main_q, mask_q, irq_q;
    logic stable_d, main_d;

    always_comb begin
        stable_d = stable_q;
        if (osc_wr)    stable_d = 1'b0;
        else if (done) stable_d = 1'b1;

        main_d = main_q;
        if (src_wr)    main_d = src_bit && stable_q;
        if (stable_q && !stable_d) main_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_on_q <= 1'b0;
            stable_q <= 1'b0;
            main_q   <= 1'b0;
            mask_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (osc_wr)  osc_on_q <= osc_bit;
            if (mask_wr) mask_q   <= mask_bit;
            stable_q <= stable_d;
            main_q   <= main_d;
            irq_q    <= stable_d && !stable_q && mask_q;
        end
    end

    assign osc_on   = osc_on_q;
    assign stable   = stable_q;
    assign main_sel = main_q;
    assign irq      = irq_q;

    assert_off_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (osc_wr && !osc_bit) |=> (!stable_q && !osc_on_q));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (stable_q && !osc_wr) |=> stable_q);

    assert_irq_edge_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (stable_q && !$past(stable_q)));

    assert_main_needs_stable_R8: assert property (@(posedge clk) disable iff (rst)
        main_q |-> stable_q);

    assert_fall_to_slow_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stable_q) |-> !main_q);

endmodule

// File: rtl/osc_startup_ctrl.sv
module osc_startup_ctrl
    import osc_startup_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int DIV_LOG2 = DIV_LOG2_DEF,
    localparam int DATA_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              osc_on_o,
    output logic              osc_stable_o,
    output logic              main_sel_o,
    output logic              irq_o
);
    wr_decode_t       dec;
    logic             flag_bit;
    logic [CNT_W-1:0] count_field;
    logic             start, halt;
    logic             tick, active, done;

    assign dec         = decode_write(wr_en, reg_sel_e'(wr_addr));
    assign flag_bit    = wr_data[0];
    assign count_field = wr_data[CNT_W:1];
    assign start       = dec.osc_wr && flag_bit;
    assign halt        = dec.osc_wr && !flag_bit;

    osc_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .run     (active),
        .tick    (tick)
    );

    osc_countdown #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (count_field),
        .stop     (halt),
        .tick     (tick),
        .active   (active),
        .done     (done)
    );

    osc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .osc_wr   (dec.osc_wr),
        .osc_bit  (flag_bit),
        .done     (done),
        .mask_wr  (dec.mask_wr),
        .mask_bit (flag_bit),
        .src_wr   (dec.src_wr),
        .src_bit  (flag_bit),
        .osc_on   (osc_on_o),
        .stable   (osc_stable_o),
        .main_sel (main_sel_o),
        .irq      (irq_o)
    );

    assert_enable_restarts_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> (osc_on_o && !osc_stable_o));

endmodule

// File: tb/osc_startup_ctrl_bench.sv
`timescale 1ns/1ps
module osc_startup_ctrl_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W:0]   wr_data = '0;
    logic             osc_on_o, osc_stable_o, main_sel_o, irq_o;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    string phase = "R1";

    // reference model state
    bit m_on = 0, m_stable = 0, m_sel = 0, m_mask = 0, m_irq = 0;
    int m_rem = 0;

    always #2.5 clk = ~clk;

    osc_startup_ctrl u_osc_startup_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .osc_on_o(osc_on_o), .osc_stable_o(osc_stable_o),
        .main_sel_o(main_sel_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit prev;
        if (rst) begin
            m_on = 0; m_stable = 0; m_sel = 0; m_mask = 0; m_irq = 0; m_rem = 0;
        end else begin
            prev = m_stable;
            if (wr_en && wr_addr == 2'd0) begin
                m_on = wr_data[0];
                m_stable = 0;
                m_rem = wr_data[0] ? 8 * ((wr_data[CNT_W:1] == 0) ? 1 : int'(wr_data[CNT_W:1])) : 0;
            end else if (m_on && !m_stable && m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) m_stable = 1;
            end
            m_irq = m_stable && !prev && m_mask;
            if (wr_en && wr_addr == 2'd1) m_mask = wr_data[0];
            if (wr_en && wr_addr == 2'd2) m_sel = wr_data[0] && prev;
            if (prev && !m_stable) m_sel = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(phase, osc_on_o,     m_on,     "model osc_on");
            check(phase, osc_stable_o, m_stable, "model stable");
            check("R9",  main_sel_o,   m_sel,    "model main_sel");
            check("R7",  irq_o,        m_irq,    "model irq");
            if (irq_o) irq_seen++;
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [CNT_W:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic enable_with(input int n);
        write_reg(2'd0, {n[CNT_W-1:0], 1'b1});
    endtask

    // returns cycles from the write edge until stable reads 1
    task automatic measure(output int cyc);
        cyc = 0;
        while (!osc_stable_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int cyc;
        int irq_before;
        fork
            begin
                #750000;
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none

        idle(3);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", osc_on_o, 0, "osc_on after reset");
        check("R1", osc_stable_o, 0, "stable after reset");
        check("R1", main_sel_o, 0, "main_sel after reset");
        check("R1", irq_o, 0, "irq after reset");

        phase = "R8";
        write_reg(2'd2, 9'd1);
        check("R8", main_sel_o, 0, "main select refused before stable");

        phase = "R4";
        irq_before = irq_seen;
        enable_with(5);
        check("R2", osc_on_o, 1, "enable visible");
        check("R2", osc_stable_o, 0, "stable cleared by enable");
        measure(cyc);
        check("R4", cyc, 40, "delay for count 5");
        check("R7", irq_seen - irq_before, 0, "no irq while masked");

        phase = "R8";
        write_reg(2'd2, 9'd1);
        check("R8", main_sel_o, 1, "main select accepted when stable");

        phase = "R5";
        idle(40);
        check("R5", osc_stable_o, 1, "stable holds");

        phase = "R3";
        write_reg(2'd0, 9'd0);
        check("R3", osc_on_o, 0, "osc off after disable");
        check("R3", osc_stable_o, 0, "stable cleared by disable");
        check("R9", main_sel_o, 0, "falls back to slow clock");
        idle(30);
        check("R3", osc_stable_o, 0, "stays unstable while off");

        phase = "R7";
        write_reg(2'd1, 9'd1);
        irq_before = irq_seen;
        enable_with(2);
        measure(cyc);
        check("R4", cyc, 16, "delay for count 2");
        idle(5);
        check("R7", irq_seen - irq_before, 1, "single irq pulse when unmasked");

        phase = "R6";
        write_reg(2'd2, 9'd1);
        enable_with(4);
        check("R9", main_sel_o, 0, "rewrite drops main select");
        idle(19);
        enable_with(4);
        measure(cyc);
        check("R6", cyc, 32, "restart re-runs full delay");
        enable_with(3);
        check("R6", osc_stable_o, 0, "rewrite while stable clears flag");
        measure(cyc);
        check("R6", cyc, 24, "delay after rewrite while stable");

        phase = "R4";
        enable_with(0);
        measure(cyc);
        check("R4", cyc, 8, "count 0 acts as one tick");
        enable_with(1);
        measure(cyc);
        check("R4", cyc, 8, "count 1");
        enable_with(255);
        measure(cyc);
        check("R4", cyc, 2040, "full-scale count 255");

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule